// File: doc/BRIEF.md
# Data-Bus Snooping Nibble Transfer Slave

This block sits beside an 8-bit processor bus where it can see only the low four data lines. It has no address lines. The processor starts a transfer by pulsing a trigger bit high and then low. It then runs a fixed sequence of three absolute-addressed instructions. The block watches that sequence nibble by nibble, at one sample per bus cycle, on the falling edge of the bus phase clock `m2`. The three instructions give twelve sampled bus cycles: opcode, address low byte, address high byte and data, repeated three times. From these cycles the block learns the following:

- whether this is a register write or a register read;
- a 24-bit tag built from the six address nibbles;
- for a write, the byte carried in the first two data cycles.

In a read, the block drives the two nibbles of `rd_data` onto the bus during the first two data cycles. In every transfer, it drives a status nibble in the last data cycle. The status nibble always differs from the open-bus value, so the processor can tell that it was heard. If the processor sees open bus, it retries.

The sequencer has five states. S_IDLE waits for the trigger. S_OPC checks the opcode nibble. S_LSB and S_MSB take the two address nibbles. S_DATA handles the data cycle. The transitions are:

- **arm:** S_IDLE goes to S_OPC on a trigger fall while `listen_en` is high.
- **opc_ok:** S_OPC goes to S_LSB.
- **opc_bad:** S_OPC goes to S_IDLE and pulses `seq_err`.
- **lsb_done:** S_LSB goes to S_MSB.
- **msb_done:** S_MSB goes to S_DATA.
- **next_ins:** S_DATA goes back to S_OPC after the first two instructions.
- **finish:** S_DATA goes to S_IDLE after the third instruction and pulses a strobe.
- **abort:** any state goes to S_IDLE while `listen_en` is low.

Top module: `nib_snoop_slave`

## Requirements
- R1: A transfer is armed only when `trig` goes from 1 to 0 while `listen_en` is 1. Without that event, no bus activity drives the bus, strobes or raises an error.
- R2: Each bus cycle contributes one nibble, taken from `d_in` while `m2` is high and registered at the `m2` falling edge. The order per instruction is opcode, address low byte, address high byte, then data, for three instructions.
- R3: Opcode low nibbles E, C, D mark a write. The written byte `wr_data` is {first data nibble, second data nibble}.
- R4: Opcode low nibbles C, E, D mark a read. The block drives `rd_data[7:4]` in the first data cycle and `rd_data[3:0]` in the second.
- R5: In the third data cycle of every accepted transfer, the block drives the bitwise inverse of that instruction's address-high nibble. This value always differs from the open-bus value.
- R6: `d_oe` is high only while `m2` is high in a driven data cycle, and falls with `m2`. `d_out` is 0 whenever `d_oe` is low.
- R7: While `listen_en` is 0, the block returns to idle. From the next clock it drives nothing and raises no strobe and no error.
- R8: `xfer_tag` is {high0, low0, high1, low1, high2, low2}. Here highK and lowK are the address nibbles of instruction K, with K counting from 0.
- R9: An opcode nibble that does not match the expected sequence returns the block to idle. It raises `seq_err` for one cycle and gives no strobe and no further drive.
- R10: A completed write pulses `wr_strobe` for exactly one clock, and a completed read pulses `rd_strobe` for exactly one clock. `wr_data` and `xfer_tag` hold their values until the next completion.
- R11: While `rst_n` is low, `d_oe`, `d_out`, both strobes, `seq_err`, `wr_data` and `xfer_tag` are 0 from the next clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock, much faster than `m2` |
| rst_n | input | 1 | Synchronous active-low reset |
| listen_en | input | 1 | Listening window enable |
| trig | input | 1 | Transfer trigger bit from the processor side |
| m2 | input | 1 | Bus phase clock, data valid while high |
| d_in | input | 4 | Low data-bus nibble as seen on the bus |
| rd_data | input | 8 | Register byte returned in a read transfer |
| d_out | output | 4 | Nibble driven onto the bus |
| d_oe | output | 1 | Bus output enable |
| wr_strobe | output | 1 | One-clock pulse on a completed write |
| rd_strobe | output | 1 | One-clock pulse on a completed read |
| wr_data | output | 8 | Byte assembled by the last write |
| xfer_tag | output | 24 | Address tag of the last completed transfer |
| seq_err | output | 1 | One-clock pulse on an opcode mismatch |

## Verification
The assertions assume the following about the bus:

- `m2` is slow against `clk`, with each phase lasting many clocks.
- `d_in` is stable for the whole high phase of a cycle.
- The trigger falls while `m2` is low and before the first opcode cycle.

The bench keeps within these assumptions. It drives every input on the falling clock edge, holds each `m2` phase for twelve or more clocks, and settles each nibble before `m2` rises. The bench also resolves the bus itself: it shows the block's nibble when `d_oe` is high, and otherwise the processor's nibble or the open-bus value.

// File: rtl/nss_pkg.sv
package nss_pkg;
    localparam int NIB_W    = 4;
    localparam int INS_N    = 3;
    localparam int INS_W    = 2;
    localparam int LAST_INS = INS_N - 1;
    localparam int BYTE_W   = 2 * NIB_W;
    localparam int TAG_W    = 2 * NIB_W * INS_N;

    typedef enum logic [2:0] {
        S_IDLE,
        S_OPC,
        S_LSB,
        S_MSB,
        S_DATA
    } seq_state_t;

    typedef enum logic {
        XF_WR = 1'b0,
        XF_RD = 1'b1
    } xfer_dir_t;

    localparam logic [NIB_W-1:0] OPN_XREG = 4'hE;
    localparam logic [NIB_W-1:0] OPN_YREG = 4'hC;
    localparam logic [NIB_W-1:0] OPN_AREG = 4'hD;

    function automatic logic [NIB_W-1:0] expected_opn(xfer_dir_t dir, logic [INS_W-1:0] idx);
        logic [NIB_W-1:0] r;
        case (idx)
            2'd0:    r = (dir == XF_WR) ? OPN_XREG : OPN_YREG;
            2'd1:    r = (dir == XF_WR) ? OPN_YREG : OPN_XREG;
            default: r = OPN_AREG;
        endcase
        return r;
    endfunction
endpackage

// File: rtl/nss_sync.sv
module nss_sync #(
    parameter int W      = 1,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    logic [W-1:0] pipe [STAGES];

    always_ff @(posedge clk) begin
        if (!rst_n) pipe[0] <= '0;
        else        pipe[0] <= din;
    end

    generate
        for (genvar g = 1; g < STAGES; g++) begin : g_stage
            always_ff @(posedge clk) begin
                if (!rst_n) pipe[g] <= '0;
                else        pipe[g] <= pipe[g-1];
            end
        end
    endgenerate

    assign dout = pipe[STAGES-1];
endmodule

// File: rtl/nss_seq.sv
module nss_seq
    import nss_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              listen_en,
    input  logic              arm,
    input  logic              smp,
    input  logic [NIB_W-1:0]  nib,
    output logic              drive_slot,
    output logic [INS_W-1:0]  drive_ins,
    output logic [NIB_W-1:0]  stat_nib,
    output logic              wr_strobe,
    output logic              rd_strobe,
    output logic              seq_err,
    output logic [BYTE_W-1:0] wr_data,
    output logic [TAG_W-1:0]  xfer_tag
);
    localparam logic [INS_W-1:0] LAST = INS_W'(LAST_INS);

    seq_state_t       state_q, state_d;
    xfer_dir_t        dir_q, dir_d;
    logic [INS_W-1:0] ins_q, ins_d;
    logic             done_wr, done_rd, bad;

    logic [TAG_W-1:0]  tag_acc;
    logic [BYTE_W-1:0] byte_acc;
    logic [NIB_W-1:0]  hi_q;
    logic [2:0]        lo_slot;

    // next state
    always_comb begin
        state_d = state_q;
        dir_d   = dir_q;
        ins_d   = ins_q;
        done_wr = 1'b0;
        done_rd = 1'b0;
        bad     = 1'b0;
        if (!listen_en) begin
            state_d = S_IDLE;
        end else begin
            unique case (state_q)
                S_IDLE: if (arm) begin
                    state_d = S_OPC;
                    ins_d   = '0;
                end
                S_OPC: if (smp) begin
                    if (ins_q == '0) begin
                        if (nib == OPN_XREG) begin
                            dir_d   = XF_WR;
                            state_d = S_LSB;
                        end else if (nib == OPN_YREG) begin
                            dir_d   = XF_RD;
                            state_d = S_LSB;
                        end else begin
                            bad     = 1'b1;
                            state_d = S_IDLE;
                        end
                    end else if (nib == expected_opn(dir_q, ins_q)) begin
                        state_d = S_LSB;
                    end else begin
                        bad     = 1'b1;
                        state_d = S_IDLE;
                    end
                end
                S_LSB:  if (smp) state_d = S_MSB;
                S_MSB:  if (smp) state_d = S_DATA;
                S_DATA: if (smp) begin
                    if (ins_q == LAST) begin
                        state_d = S_IDLE;
                        done_wr = (dir_q == XF_WR);
                        done_rd = (dir_q == XF_RD);
                    end else begin
                        ins_d   = ins_q + 1'b1;
                        state_d = S_OPC;
                    end
                end
                default: state_d = S_IDLE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
            dir_q   <= XF_WR;
            ins_q   <= '0;
        end else begin
            state_q <= state_d;
            dir_q   <= dir_d;
            ins_q   <= ins_d;
        end
    end

    // tag slot of the low address nibble of the current instruction
    assign lo_slot = 3'(2 * (LAST_INS - int'(ins_q)));

    // captured fields and outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tag_acc   <= '0;
            byte_acc  <= '0;
            hi_q      <= '0;
            wr_strobe <= 1'b0;
            rd_strobe <= 1'b0;
            seq_err   <= 1'b0;
            wr_data   <= '0;
            xfer_tag  <= '0;
        end else begin
            wr_strobe <= done_wr;
            rd_strobe <= done_rd;
            seq_err   <= bad;
            if (state_q == S_IDLE && arm) begin
                tag_acc <= '0;
            end
            if (listen_en && smp) begin
                case (state_q)
                    S_LSB: tag_acc[int'(lo_slot) * NIB_W +: NIB_W] <= nib;
                    S_MSB: begin
                        tag_acc[(int'(lo_slot) + 1) * NIB_W +: NIB_W] <= nib;
                        hi_q <= nib;
                    end
                    S_DATA: if (dir_q == XF_WR) begin
                        if (ins_q == 2'd0) byte_acc[BYTE_W-1 -: NIB_W] <= nib;
                        if (ins_q == 2'd1) byte_acc[NIB_W-1:0]         <= nib;
                    end
                    default: ;
                endcase
            end
            if (done_wr) begin
                wr_data  <= byte_acc;
                xfer_tag <= tag_acc;
            end
            if (done_rd) begin
                xfer_tag <= tag_acc;
            end
        end
    end

    assign drive_slot = (state_q == S_DATA) && ((dir_q == XF_RD) || (ins_q == LAST));
    assign drive_ins  = ins_q;
    assign stat_nib   = ~hi_q;
endmodule

// File: rtl/nss_drive.sv
module nss_drive
    import nss_pkg::*;
(
    input  logic              slot,
    input  logic              m2,
    input  logic [INS_W-1:0]  ins,
    input  logic [NIB_W-1:0]  stat,
    input  logic [BYTE_W-1:0] rd_data,
    output logic [NIB_W-1:0]  d_out,
    output logic              d_oe
);
    logic [NIB_W-1:0] val;

    always_comb begin
        case (ins)
            2'd0:    val = rd_data[BYTE_W-1 -: NIB_W];
            2'd1:    val = rd_data[NIB_W-1:0];
            default: val = stat;
        endcase
    end

    assign d_oe  = slot & m2;
    assign d_out = d_oe ? val : '0;
endmodule

// File: rtl/nib_snoop_slave.sv
module nib_snoop_slave
    import nss_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              listen_en,
    input  logic              trig,
    input  logic              m2,
    input  logic [NIB_W-1:0]  d_in,
    input  logic [BYTE_W-1:0] rd_data,
    output logic [NIB_W-1:0]  d_out,
    output logic              d_oe,
    output logic              wr_strobe,
    output logic              rd_strobe,
    output logic [BYTE_W-1:0] wr_data,
    output logic [TAG_W-1:0]  xfer_tag,
    output logic              seq_err
);
    localparam int SW = NIB_W + 2;

    logic [SW-1:0]    sync_out;
    logic             trig_s, m2_s, trig_q, m2_q;
    logic [NIB_W-1:0] d_s, d_hold;
    logic             arm, smp;
    logic             drive_slot;
    logic [INS_W-1:0] drive_ins;
    logic [NIB_W-1:0] stat_nib;

    nss_sync #(.W(SW), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   ({trig, m2, d_in}),
        .dout  (sync_out)
    );

    assign trig_s = sync_out[SW-1];
    assign m2_s   = sync_out[SW-2];
    assign d_s    = sync_out[NIB_W-1:0];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            trig_q <= 1'b0;
            m2_q   <= 1'b0;
            d_hold <= '0;
        end else begin
            trig_q <= trig_s;
            m2_q   <= m2_s;
            if (m2_s) d_hold <= d_s;
        end
    end

    assign arm = trig_q & ~trig_s;
    assign smp = m2_q & ~m2_s;

    nss_seq u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .listen_en  (listen_en),
        .arm        (arm),
        .smp        (smp),
        .nib        (d_hold),
        .drive_slot (drive_slot),
        .drive_ins  (drive_ins),
        .stat_nib   (stat_nib),
        .wr_strobe  (wr_strobe),
        .rd_strobe  (rd_strobe),
        .seq_err    (seq_err),
        .wr_data    (wr_data),
        .xfer_tag   (xfer_tag)
    );

    nss_drive u_drive (
        .slot    (drive_slot),
        .m2      (m2),
        .ins     (drive_ins),
        .stat    (stat_nib),
        .rd_data (rd_data),
        .d_out   (d_out),
        .d_oe    (d_oe)
    );
endmodule

// File: rtl/nss_chk.sv
module nss_chk (
    input logic clk,
    input logic rst_n,
    input logic listen_en,
    input logic m2,
    input logic d_oe,
    input logic wr_strobe,
    input logic rd_strobe,
    input logic seq_err
);
    // R6
    oe_only_m2_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        d_oe |-> m2);

    // R10
    wr_pulse_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_strobe |=> !wr_strobe);

    // R10
    rd_pulse_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_strobe |=> !rd_strobe);

    // R9
    events_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({wr_strobe, rd_strobe, seq_err}));

    // R7
    quiet_when_deaf_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(listen_en) |-> (!d_oe && !wr_strobe && !rd_strobe && !seq_err));

    // R11
    reset_quiet_chk: assert property (@(posedge clk)
        !rst_n |=> (!wr_strobe && !rd_strobe && !seq_err));
endmodule

bind nib_snoop_slave nss_chk u_nss_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .listen_en (listen_en),
    .m2        (m2),
    .d_oe      (d_oe),
    .wr_strobe (wr_strobe),
    .rd_strobe (rd_strobe),
    .seq_err   (seq_err)
);

// File: tb/nib_snoop_slave_test.sv
`timescale 1ns/1ps
module nib_snoop_slave_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        listen_en = 1'b0;
    logic        trig = 1'b0;
    logic        m2 = 1'b0;
    logic [3:0]  cpu_nib = 4'h0;
    logic [7:0]  rd_data = 8'h00;
    logic [3:0]  d_out;
    logic        d_oe;
    logic        wr_strobe, rd_strobe, seq_err;
    logic [7:0]  wr_data;
    logic [23:0] xfer_tag;
    logic [3:0]  bus;

    int n_chk = 0, n_fail = 0;
    int n_wr = 0, n_rd = 0, n_err = 0;
    logic [7:0]  cap_data = 8'h00;
    logic [23:0] cap_tag = 24'h0;
    logic [3:0]  got_v [3];
    logic        got_oe [3];
    bit          finished = 1'b0;

    always #10 clk = ~clk;

    assign bus = d_oe ? d_out : cpu_nib;

    nib_snoop_slave uut (
        .clk(clk), .rst_n(rst_n), .listen_en(listen_en), .trig(trig), .m2(m2),
        .d_in(bus), .rd_data(rd_data), .d_out(d_out), .d_oe(d_oe),
        .wr_strobe(wr_strobe), .rd_strobe(rd_strobe), .wr_data(wr_data),
        .xfer_tag(xfer_tag), .seq_err(seq_err)
    );

    always @(negedge clk) begin
        if (rst_n) begin
            if (wr_strobe) begin n_wr++; cap_data = wr_data; cap_tag = xfer_tag; end
            if (rd_strobe) begin n_rd++; cap_tag = xfer_tag; end
            if (seq_err)   n_err++;
        end
    end

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic bus_cyc(input logic [3:0] n, input int k);
        @(negedge clk);
        m2 = 1'b0;
        cpu_nib = n;
        repeat (12) @(negedge clk);
        m2 = 1'b1;
        repeat (12) @(negedge clk);
        if (k >= 0) begin
            got_oe[k] = d_oe;
            got_v[k]  = d_out;
        end
        @(negedge clk);
    endtask

    task automatic bus_end();
        @(negedge clk);
        m2 = 1'b0;
        repeat (12) @(negedge clk);
    endtask

    task automatic pulse_trig();
        @(negedge clk);
        trig = 1'b1;
        repeat (4) @(negedge clk);
        trig = 1'b0;
        repeat (6) @(negedge clk);
    endtask

    // full three-instruction sequence
    task automatic do_xfer(input logic [11:0] ops, input logic [23:0] tag,
                           input logic [7:0] wbyte, input bit cpu_stores);
        for (int k = 0; k < 3; k++) begin
            got_oe[k] = 1'b0;
            got_v[k]  = 4'h0;
        end
        pulse_trig();
        for (int k = 0; k < 3; k++) begin
            logic [3:0] hi, lo, dn;
            hi = tag[23 - 8*k -: 4];
            lo = tag[19 - 8*k -: 4];
            if (cpu_stores && k < 2) dn = (k == 0) ? wbyte[7:4] : wbyte[3:0];
            else                     dn = hi;
            bus_cyc(ops[11 - 4*k -: 4], -1);
            bus_cyc(lo, -1);
            bus_cyc(hi, -1);
            bus_cyc(dn, k);
        end
        bus_end();
    endtask

    // ops[11:0], tag[23:0], wbyte[7:0], rd[7:0], listen
    localparam int NV = 8;
    localparam logic [52:0] VEC [NV] = '{
        {12'hECD, 24'hC3185A, 8'h5A, 8'h00, 1'b1},
        {12'hCED, 24'hC3185A, 8'h00, 8'hA7, 1'b1},
        {12'hECD, 24'h0F0F0F, 8'hFF, 8'h11, 1'b1},
        {12'hCED, 24'hFFFFFF, 8'h00, 8'h3C, 1'b1},
        {12'h3CD, 24'h123456, 8'h99, 8'h00, 1'b1},
        {12'hCCD, 24'h654321, 8'h00, 8'hB2, 1'b1},
        {12'hECE, 24'hABCDEF, 8'h77, 8'h00, 1'b1},
        {12'hECD, 24'h2468AC, 8'h42, 8'h00, 1'b0}
    };

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        // R11: reset state
        repeat (5) @(negedge clk);
        check(d_oe == 1'b0 && d_out == 4'h0, "R11 bus idle in reset", {d_oe, d_out}, 0);
        check(wr_strobe == 0 && rd_strobe == 0 && seq_err == 0, "R11 pulses low in reset",
              {wr_strobe, rd_strobe, seq_err}, 0);
        check(wr_data == 8'h00 && xfer_tag == 24'h0, "R11 captures clear in reset",
              {wr_data, xfer_tag}, 0);
        rst_n = 1'b1;
        listen_en = 1'b1;
        repeat (5) @(negedge clk);

        // R1: bus traffic without a trigger is ignored
        begin
            int w0, r0, e0;
            w0 = n_wr; r0 = n_rd; e0 = n_err;
            bus_cyc(4'hE, -1); bus_cyc(4'h3, -1); bus_cyc(4'hC, -1); bus_cyc(4'h1, 0);
            bus_end();
            check(got_oe[0] == 1'b0, "R1 no drive without trigger", got_oe[0], 0);
            check(n_wr == w0 && n_rd == r0 && n_err == e0, "R1 no events without trigger",
                  n_wr + n_rd + n_err, w0 + r0 + e0);
        end

        // vector table
        for (int v = 0; v < NV; v++) begin
            logic [11:0] ops;
            logic [23:0] tag;
            logic [7:0]  wb, rdd;
            bit          lis, is_wr, is_rd, e_err;
            bit          ok [3];
            logic [11:0] pat;
            int          w0, r0, e0;
            {ops, tag, wb, rdd, lis} = VEC[v];
            is_wr = (ops[11:8] == 4'hE);
            is_rd = (ops[11:8] == 4'hC);
            pat   = is_wr ? 12'hECD : 12'hCED;
            for (int k = 0; k < 3; k++)
                ok[k] = lis && (is_wr || is_rd) && (ops[11 -: 4] == pat[11 -: 4]) &&
                        (k < 1 || ops[7:4] == pat[7:4]) && (k < 2 || ops[3:0] == pat[3:0]);
            e_err = lis && !ok[2];
            listen_en = lis;
            rd_data = rdd;
            w0 = n_wr; r0 = n_rd; e0 = n_err;
            do_xfer(ops, tag, wb, is_wr && ok[0]);
            repeat (8) @(negedge clk);
            for (int k = 0; k < 3; k++) begin
                bit eoe;
                logic [3:0] ev;
                eoe = ok[k] && (is_rd || k == 2);
                ev  = (k == 2) ? ~tag[7:4] : (k == 0 ? rdd[7:4] : rdd[3:0]);
                if (!lis)
                    check(got_oe[k] == eoe, "R7 no drive when deaf", got_oe[k], eoe);
                else if (!ok[k])
                    check(got_oe[k] == eoe, "R9 no drive after mismatch", got_oe[k], eoe);
                else
                    check(got_oe[k] == eoe, "R6 drive enable per data cycle", got_oe[k], eoe);
                if (eoe) begin
                    if (k == 2) begin
                        check(got_v[k] == ev, "R5 status is inverted high nibble", got_v[k], ev);
                        check(got_v[k] != tag[7:4], "R5 status differs from open bus",
                              got_v[k], tag[7:4]);
                    end else begin
                        check(got_v[k] == ev, "R4 read nibble", got_v[k], ev);
                    end
                end
            end
            check(n_err - e0 == int'(e_err), "R9 error pulse count", n_err - e0, e_err);
            check(n_wr - w0 == int'(ok[2] && is_wr), "R10 write strobe count", n_wr - w0,
                  ok[2] && is_wr);
            check(n_rd - r0 == int'(ok[2] && is_rd), "R10 read strobe count", n_rd - r0,
                  ok[2] && is_rd);
            if (ok[2] && is_wr) begin
                check(cap_data == wb, "R3 assembled write byte", cap_data, wb);
                check(wr_data == wb, "R10 write byte held", wr_data, wb);
            end
            if (ok[2]) begin
                check(cap_tag == tag, "R8 address tag", cap_tag, tag);
                check(xfer_tag == tag, "R2 tag held after transfer", xfer_tag, tag);
            end
        end

        // R7: listen window closed in the middle of a read
        begin
            int w0, r0, e0;
            listen_en = 1'b1;
            rd_data = 8'h96;
            w0 = n_wr; r0 = n_rd; e0 = n_err;
            pulse_trig();
            bus_cyc(4'hC, -1); bus_cyc(4'h1, -1); bus_cyc(4'h2, -1); bus_cyc(4'h2, 0);
            check(got_oe[0] == 1'b1 && got_v[0] == 4'h9, "R4 first read nibble before drop",
                  {got_oe[0], got_v[0]}, 5'h19);
            @(negedge clk);
            listen_en = 1'b0;
            bus_cyc(4'hE, -1); bus_cyc(4'h3, -1); bus_cyc(4'h4, -1); bus_cyc(4'h4, 1);
            bus_cyc(4'hD, -1); bus_cyc(4'h5, -1); bus_cyc(4'h6, -1); bus_cyc(4'h6, 2);
            bus_end();
            repeat (8) @(negedge clk);
            check(got_oe[1] == 1'b0 && got_oe[2] == 1'b0, "R7 no drive after window closed",
                  {got_oe[1], got_oe[2]}, 0);
            check(n_wr == w0 && n_rd == r0 && n_err == e0, "R7 no events after window closed",
                  n_wr + n_rd + n_err, w0 + r0 + e0);
            check(d_oe == 1'b0 && d_out == 4'h0, "R6 output zero when idle", {d_oe, d_out}, 0);
        end

        // R3/R10: a good write after the aborted read still works, and the earlier capture holds
        listen_en = 1'b1;
        do_xfer(12'hECD, 24'h9E1D3B, 8'hC4, 1'b1);
        repeat (8) @(negedge clk);
        check(wr_data == 8'hC4, "R3 write after abort", wr_data, 8'hC4);
        check(xfer_tag == 24'h9E1D3B, "R8 tag after abort", xfer_tag, 24'h9E1D3B);
        check(got_oe[2] == 1'b1 && got_v[2] == 4'hC, "R5 status after abort",
              {got_oe[2], got_v[2]}, 5'h1C);

        finished = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule